// File: doc/BRIEF.md
# Set-Associative Instruction TLB

This block translates 32-bit instruction-fetch virtual addresses into physical addresses. Translations live in two register arrays, a match array (tag, valid bit, age) and a translate array (physical page number, cache-inhibit bit and execute permissions). Each array is organised as `NSETS` sets of `NWAYS` ways. A fetch request is looked up combinationally. The result is registered, so the response appears one clock after the request. It carries either the physical address or an exception flag: a TLB miss, or an execute-permission page fault.

Software fills the arrays through a one-word write port and can inspect any entry through a combinational read port. A separate probe port translates a second address for debug. The probe never changes any state and never flags an exception. Each hit updates the per-entry age counters of the addressed set, which refill software uses to choose a victim. When translation is switched off, or the unit is declared absent, addresses pass through unchanged.

Top module: `itlb_xlate`

## Requirements
- R1: When `xlate_en` or `mmu_present` is low, a fetch response returns the request address as the physical address, with `rsp_pa_valid` high and no hit, miss or fault. In this case `rsp_ci` equals bit 31 of the address, that is, the address is at or above 0x8000_0000.
- R2: The set index is (address >> PAGE_LOG2) & (NSETS-1). The tag compared is the address with its low log2(PAGE_SIZE*NSETS) bits cleared, which is bits [31:17] by default. The same tag in another set, or another tag in the same set, does not hit.
- R3: A way hits only when its match word has bit 0 (valid) set and its tag equals the address tag. When several ways hit, the lowest-numbered way is used.
- R4: On a fetch hit, every way of that set whose 2-bit age field (match word bits [7:6]) is nonzero is decremented by one. After that, the hit way's age is OR-ed with (NSETS-1) limited to the field width, which is 3 by default.
- R5: On a permitted hit, the physical address is the translate word with its low PAGE_LOG2 bits cleared, OR-ed with the low PAGE_LOG2 bits of the request address.
- R6: In supervisor mode (`sup_mode`=1) a hit requires translate bit 7. In user mode it requires translate bit 6. When the required bit is clear, the response shows `rsp_hit` and `rsp_fault` with `rsp_pa_valid` low. The age update still takes place.
- R7: On a hit, `rsp_ci` equals translate bit 1.
- R8: On a miss, `rsp_miss` is set, `rsp_pa_valid` is low, `rsp_vaddr` holds the request address, and no entry changes.
- R9: The probe port returns the translation of `prb_vaddr`. It returns 0 on a miss or a permission failure. When translation is off it returns the input address. A probe never alters any age field.
- R10: `cfg_word` reads log2(NSETS) in bits [7:3] and NWAYS-1 in bits [1:0], with all other bits zero. The default value is 0x21.
- R11: Each fetch request produces exactly one response one clock later. No response appears without a request. A response never carries both a miss and a fault.
- R12: After reset, all response flags are low and every match and translate word reads zero, so no entry is valid.
- R13: A write stores `wr_data` into the selected word: translate if `wr_tr`=1, match otherwise. If the write targets an entry in the same cycle as a fetch hit ages it, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable from the status word |
| mmu_present | input | 1 | Unit implemented flag |
| sup_mode | input | 1 | Supervisor mode when high |
| req_valid | input | 1 | Fetch request strobe |
| req_vaddr | input | 32 | Fetch virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_pa_valid | output | 1 | Physical address usable |
| rsp_paddr | output | 32 | Physical address |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | TLB miss exception |
| rsp_fault | output | 1 | Execute-permission page fault |
| rsp_ci | output | 1 | Cache inhibit |
| rsp_vaddr | output | 32 | Request address of this response |
| prb_vaddr | input | 32 | Debug probe address |
| prb_paddr | output | 32 | Probe translation or 0 |
| wr_en | input | 1 | Entry write strobe |
| wr_tr | input | 1 | 1 writes the translate word, 0 the match word |
| wr_way | input | 1 | Way written |
| wr_set | input | 4 | Set written |
| wr_data | input | 32 | Word written |
| rd_tr | input | 1 | 1 reads the translate word, 0 the match word |
| rd_way | input | 1 | Way read |
| rd_set | input | 4 | Set read |
| rd_data | output | 32 | Word read |
| cfg_word | output | 32 | Geometry word |

## Verification
Fetches are tried in five situations: with translation off, on an address below and an address above the 0x8000_0000 boundary; against an empty array; against one valid way; against two ways holding the same tag; and with addresses that share the tag but not the set, or the set but not the tag. Together these separate pass-through, miss detection, index and tag slicing, and lowest-way priority. Permission patterns cover every combination of mode and execute bit, which distinguishes a fault from a clean hit. Age values are read back after hits from preset ages, after misses and after probes, which shows whether a state change came from the fetch path or from the side-effect-free path. A write that lands in the same cycle as an aging hit confirms the write priority.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int unsigned VA_W       = 32;
  typedef logic [VA_W-1:0] word_t;

  // match word fields
  localparam int unsigned MV_VALID   = 0;
  localparam int unsigned MV_AGE_LSB = 6;
  // translate word fields
  localparam int unsigned TE_CI      = 1;
  localparam int unsigned TE_UX      = 6;
  localparam int unsigned TE_SX      = 7;

  typedef enum logic {SEL_MATCH = 1'b0, SEL_XLATE = 1'b1} tsel_e;

  typedef struct packed {
    logic valid;
    logic pa_valid;
    logic hit;
    logic miss;
    logic fault;
    logic ci;
  } rsp_flags_t;
endpackage

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
#(
  parameter int unsigned NWAYS = 2,
  parameter int unsigned NSETS = 16,
  parameter int unsigned AGE_W = 2,
  parameter int unsigned SET_W = 4,
  parameter int unsigned WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tsel_e            wr_sel,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [SET_W-1:0] wr_set,
  input  word_t            wr_data,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic [NWAYS-1:0] upd_hit,
  input  logic [SET_W-1:0] f_set,
  input  logic [SET_W-1:0] p_set,
  input  tsel_e            rd_sel,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_set,
  output word_t            f_mr [NWAYS],
  output word_t            f_tr [NWAYS],
  output word_t            p_mr [NWAYS],
  output word_t            p_tr [NWAYS],
  output word_t            rd_data
);
  localparam logic [AGE_W-1:0] RELOAD = AGE_W'((NSETS - 1) & ((1 << AGE_W) - 1));

  word_t mr_q [NWAYS][NSETS];
  word_t tr_q [NWAYS][NSETS];
  word_t mr_d [NWAYS][NSETS];
  word_t tr_d [NWAYS][NSETS];
  logic  st_en;

  function automatic word_t age_step(word_t m, logic reload);
    logic [AGE_W-1:0] a;
    a = m[MV_AGE_LSB +: AGE_W];
    if (a != '0) a = a - 1'b1;
    if (reload)  a = a | RELOAD;
    m[MV_AGE_LSB +: AGE_W] = a;
    return m;
  endfunction

  always_comb begin
    mr_d = mr_q;
    tr_d = tr_q;
    for (int w = 0; w < NWAYS; w++) begin
      for (int s = 0; s < NSETS; s++) begin
        if (upd_en && upd_set == SET_W'(s))
          mr_d[w][s] = age_step(mr_q[w][s], upd_hit[w]);
        if (wr_en && wr_way == WAY_W'(w) && wr_set == SET_W'(s)) begin
          if (wr_sel == SEL_MATCH) mr_d[w][s] = wr_data;
          else                     tr_d[w][s] = wr_data;
        end
      end
    end
  end

  assign st_en = wr_en | upd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q <= '{default: '0};
      tr_q <= '{default: '0};
    end else if (st_en) begin
      mr_q <= mr_d;
      tr_q <= tr_d;
    end
  end

  for (genvar g = 0; g < NWAYS; g++) begin : g_row
    assign f_mr[g] = mr_q[g][f_set];
    assign f_tr[g] = tr_q[g][f_set];
    assign p_mr[g] = mr_q[g][p_set];
    assign p_tr[g] = tr_q[g][p_set];
  end

  assign rd_data = (rd_sel == SEL_MATCH) ? mr_q[rd_way][rd_set] : tr_q[rd_way][rd_set];
endmodule

// File: rtl/itlb_match.sv
module itlb_match
  import itlb_pkg::*;
#(
  parameter int unsigned NWAYS   = 2,
  parameter int unsigned TAG_LSB = 17
) (
  input  word_t            vaddr,
  input  word_t            mr [NWAYS],
  input  word_t            tr [NWAYS],
  output logic [NWAYS-1:0] hit_vec,
  output word_t            sel_tr
);
  localparam word_t TAG_MASK = ~word_t'((64'd1 << TAG_LSB) - 64'd1);

  logic found;

  // first matching way in index order wins
  always_comb begin
    hit_vec = '0;
    sel_tr  = '0;
    found   = 1'b0;
    for (int w = 0; w < NWAYS; w++) begin
      if (!found && mr[w][MV_VALID] && (((mr[w] ^ vaddr) & TAG_MASK) == '0)) begin
        hit_vec[w] = 1'b1;
        sel_tr     = tr[w];
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int unsigned NWAYS     = 2,
  parameter int unsigned NSETS     = 16,
  parameter int unsigned PAGE_LOG2 = 13,
  parameter int unsigned AGE_W     = 2,
  localparam int unsigned SET_LOG2 = $clog2(NSETS),
  localparam int unsigned SET_W    = (SET_LOG2 > 0) ? SET_LOG2 : 1,
  localparam int unsigned WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlate_en,
  input  logic             mmu_present,
  input  logic             sup_mode,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_pa_valid,
  output logic [31:0]      rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic             rsp_ci,
  output logic [31:0]      rsp_vaddr,
  input  logic [31:0]      prb_vaddr,
  output logic [31:0]      prb_paddr,
  input  logic             wr_en,
  input  logic             wr_tr,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [SET_W-1:0] wr_set,
  input  logic [31:0]      wr_data,
  input  logic             rd_tr,
  input  logic [WAY_W-1:0] rd_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [31:0]      rd_data,
  output logic [31:0]      cfg_word
);
  localparam int unsigned TAG_LSB  = PAGE_LOG2 + SET_LOG2;
  localparam word_t       OFF_MASK = word_t'((64'd1 << PAGE_LOG2) - 64'd1);

  logic             bypass;
  logic [SET_W-1:0] f_set, p_set;
  word_t            f_mr [NWAYS];
  word_t            f_tr [NWAYS];
  word_t            p_mr [NWAYS];
  word_t            p_tr [NWAYS];
  logic [NWAYS-1:0] f_hitv, p_hitv;
  word_t            f_sel, p_sel;
  logic             f_hit, p_hit, f_ok, p_ok;
  word_t            f_pa, p_pa;
  logic             upd_en;

  rsp_flags_t       flg_d, flg_q;
  word_t            pa_d, pa_q, va_q;

  function automatic word_t join_pa(word_t t, word_t va);
    return (t & ~OFF_MASK) | (va & OFF_MASK);
  endfunction

  assign bypass = !(xlate_en && mmu_present);
  assign f_set  = SET_W'((req_vaddr >> PAGE_LOG2) & (NSETS - 1));
  assign p_set  = SET_W'((prb_vaddr >> PAGE_LOG2) & (NSETS - 1));

  itlb_store #(
    .NWAYS(NWAYS), .NSETS(NSETS), .AGE_W(AGE_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (tsel_e'(wr_tr)),
    .wr_way  (wr_way),
    .wr_set  (wr_set),
    .wr_data (wr_data),
    .upd_en  (upd_en),
    .upd_set (f_set),
    .upd_hit (f_hitv),
    .f_set   (f_set),
    .p_set   (p_set),
    .rd_sel  (tsel_e'(rd_tr)),
    .rd_way  (rd_way),
    .rd_set  (rd_set),
    .f_mr    (f_mr),
    .f_tr    (f_tr),
    .p_mr    (p_mr),
    .p_tr    (p_tr),
    .rd_data (rd_data)
  );

  itlb_match #(.NWAYS(NWAYS), .TAG_LSB(TAG_LSB)) u_fetch_match (
    .vaddr (req_vaddr), .mr (f_mr), .tr (f_tr), .hit_vec (f_hitv), .sel_tr (f_sel)
  );

  itlb_match #(.NWAYS(NWAYS), .TAG_LSB(TAG_LSB)) u_probe_match (
    .vaddr (prb_vaddr), .mr (p_mr), .tr (p_tr), .hit_vec (p_hitv), .sel_tr (p_sel)
  );

  assign f_hit = |f_hitv;
  assign p_hit = |p_hitv;
  assign f_ok  = sup_mode ? f_sel[TE_SX] : f_sel[TE_UX];
  assign p_ok  = sup_mode ? p_sel[TE_SX] : p_sel[TE_UX];
  assign f_pa  = join_pa(f_sel, req_vaddr);
  assign p_pa  = join_pa(p_sel, prb_vaddr);

  // ages move only on a real fetch hit
  assign upd_en = req_valid && !bypass && f_hit;

  // probe path: no state, no exceptions
  always_comb begin
    if (bypass)            prb_paddr = prb_vaddr;
    else if (p_hit && p_ok) prb_paddr = p_pa;
    else                   prb_paddr = '0;
  end

  // response next state
  always_comb begin
    flg_d = '0;
    pa_d  = '0;
    if (req_valid) begin
      flg_d.valid = 1'b1;
      if (bypass) begin
        flg_d.pa_valid = 1'b1;
        flg_d.ci       = req_vaddr[31];
        pa_d           = req_vaddr;
      end else if (f_hit) begin
        flg_d.hit      = 1'b1;
        flg_d.fault    = !f_ok;
        flg_d.pa_valid = f_ok;
        flg_d.ci       = f_sel[TE_CI];
        pa_d           = f_pa;
      end else begin
        flg_d.miss     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      va_q <= '0;
    end else if (req_valid) begin
      pa_q <= pa_d;
      va_q <= req_vaddr;
    end
  end

  assign rsp_valid    = flg_q.valid;
  assign rsp_pa_valid = flg_q.pa_valid;
  assign rsp_hit      = flg_q.hit;
  assign rsp_miss     = flg_q.miss;
  assign rsp_fault    = flg_q.fault;
  assign rsp_ci       = flg_q.ci;
  assign rsp_paddr    = pa_q;
  assign rsp_vaddr    = va_q;
  assign cfg_word     = 32'((SET_LOG2 << 3) | (NWAYS - 1));
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlate_en,
  input logic        mmu_present,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic        rsp_valid,
  input logic        rsp_pa_valid,
  input logic [31:0] rsp_paddr,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic        rsp_fault,
  input logic        rsp_ci,
  input logic [31:0] rsp_vaddr,
  input logic [31:0] prb_vaddr,
  input logic [31:0] prb_paddr
);
  assert_one_exception_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_miss, rsp_fault}));

  assert_resp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_valid == $past(req_valid)));

  assert_miss_reports_va_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_pa_valid && !rsp_hit && rsp_vaddr == $past(req_vaddr)));

  assert_fault_blocks_pa_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && !rsp_pa_valid));

  assert_bypass_passthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid) && !$past(xlate_en && mmu_present)) |->
      (rsp_pa_valid && rsp_paddr == $past(req_vaddr) && rsp_ci == $past(req_vaddr[31])));

  assert_probe_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlate_en && mmu_present) |-> (prb_paddr == prb_vaddr));
endmodule

bind itlb_xlate itlb_xlate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xlate_en     (xlate_en),
  .mmu_present  (mmu_present),
  .req_valid    (req_valid),
  .req_vaddr    (req_vaddr),
  .rsp_valid    (rsp_valid),
  .rsp_pa_valid (rsp_pa_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_fault    (rsp_fault),
  .rsp_ci       (rsp_ci),
  .rsp_vaddr    (rsp_vaddr),
  .prb_vaddr    (prb_vaddr),
  .prb_paddr    (prb_paddr)
);

// File: tb/sim_itlb_xlate.sv
module sim_itlb_xlate;
  localparam int NW = 2;
  localparam int NS = 16;
  localparam int PL = 13;

  logic clk, rst_n;
  logic xlate_en, mmu_present, sup_mode;
  logic req_valid;
  logic [31:0] req_vaddr;
  logic rsp_valid, rsp_pa_valid, rsp_hit, rsp_miss, rsp_fault, rsp_ci;
  logic [31:0] rsp_paddr, rsp_vaddr;
  logic [31:0] prb_vaddr, prb_paddr;
  logic wr_en, wr_tr, rd_tr;
  logic [0:0] wr_way, rd_way;
  logic [3:0] wr_set, rd_set;
  logic [31:0] wr_data, rd_data, cfg_word;

  itlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .mmu_present(mmu_present),
    .sup_mode(sup_mode), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_pa_valid(rsp_pa_valid), .rsp_paddr(rsp_paddr),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_ci(rsp_ci),
    .rsp_vaddr(rsp_vaddr), .prb_vaddr(prb_vaddr), .prb_paddr(prb_paddr),
    .wr_en(wr_en), .wr_tr(wr_tr), .wr_way(wr_way), .wr_set(wr_set), .wr_data(wr_data),
    .rd_tr(rd_tr), .rd_way(rd_way), .rd_set(rd_set), .rd_data(rd_data), .cfg_word(cfg_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R12";

  bit [31:0] m_mr [NW][NS];
  bit [31:0] m_tr [NW][NS];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_set(bit [31:0] va);
    return int'((va >> PL) & (NS - 1));
  endfunction

  function automatic bit [31:0] m_tag(bit [31:0] va);
    return va & ~((32'(NS) << PL) - 32'd1);
  endfunction

  function automatic int m_find(bit [31:0] va);
    int s = m_set(va);
    for (int w = 0; w < NW; w++)
      if (m_mr[w][s][0] && m_tag(m_mr[w][s]) == m_tag(va)) return w;
    return -1;
  endfunction

  function automatic bit [31:0] m_pa(bit [31:0] t, bit [31:0] va);
    bit [31:0] om = (32'd1 << PL) - 32'd1;
    return (t & ~om) | (va & om);
  endfunction

  // one clock: combinational checks, edge, model update, registered checks
  task automatic tick();
    bit byp;
    int hw, s;
    bit [31:0] t, e_pa, e_prb;
    bit e_v, e_pav, e_hit, e_miss, e_flt, e_ci, ok;
    #1;
    byp = !(xlate_en && mmu_present);
    // probe (R9)
    hw = m_find(prb_vaddr);
    if (byp) e_prb = prb_vaddr;
    else if (hw >= 0) begin
      t = m_tr[hw][m_set(prb_vaddr)];
      ok = sup_mode ? t[7] : t[6];
      e_prb = ok ? m_pa(t, prb_vaddr) : 32'd0;
    end else e_prb = 32'd0;
    check(cur_req, "prb_paddr", prb_paddr, e_prb);
    check(cur_req, "rd_data", rd_data, rd_tr ? m_tr[rd_way][rd_set] : m_mr[rd_way][rd_set]);
    check("R10", "cfg_word", cfg_word, 32'h21);
    // fetch expectation
    {e_v, e_pav, e_hit, e_miss, e_flt, e_ci} = '0;
    e_pa = 0;
    s = m_set(req_vaddr);
    hw = -1;
    if (req_valid) begin
      e_v = 1;
      if (byp) begin
        e_pav = 1; e_pa = req_vaddr; e_ci = req_vaddr[31];
      end else begin
        hw = m_find(req_vaddr);
        if (hw < 0) e_miss = 1;
        else begin
          t = m_tr[hw][s];
          ok = sup_mode ? t[7] : t[6];
          e_hit = 1; e_flt = !ok; e_pav = ok; e_ci = t[1];
          e_pa = m_pa(t, req_vaddr);
        end
      end
    end
    @(posedge clk);
    if (hw >= 0) begin
      for (int w = 0; w < NW; w++) begin
        bit [1:0] a = m_mr[w][s][7:6];
        if (a != 0) a = a - 1;
        if (w == hw) a = a | 2'd3;
        m_mr[w][s][7:6] = a;
      end
    end
    if (wr_en) begin
      if (wr_tr) m_tr[wr_way][wr_set] = wr_data;
      else       m_mr[wr_way][wr_set] = wr_data;
    end
    @(negedge clk);
    check(cur_req, "rsp_valid", 32'(rsp_valid), 32'(e_v));
    check(cur_req, "rsp_pa_valid", 32'(rsp_pa_valid), 32'(e_pav));
    check(cur_req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
    check(cur_req, "rsp_miss", 32'(rsp_miss), 32'(e_miss));
    check(cur_req, "rsp_fault", 32'(rsp_fault), 32'(e_flt));
    check(cur_req, "rsp_ci", 32'(rsp_ci), 32'(e_ci));
    if (e_v) check(cur_req, "rsp_vaddr", rsp_vaddr, req_vaddr);
    if (e_pav) check(cur_req, "rsp_paddr", rsp_paddr, e_pa);
  endtask

  task automatic fetch(bit [31:0] va);
    req_valid = 1; req_vaddr = va;
    tick();
    req_valid = 0;
  endtask

  task automatic put(bit tr, int w, int s, bit [31:0] d);
    wr_en = 1; wr_tr = tr; wr_way = 1'(w); wr_set = 4'(s); wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic look(bit tr, int w, int s);
    rd_tr = tr; rd_way = 1'(w); rd_set = 4'(s);
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    bit [31:0] A, B, C, D;
    int sa;
    rst_n = 0; xlate_en = 0; mmu_present = 0; sup_mode = 0;
    req_valid = 0; req_vaddr = 0; prb_vaddr = 0;
    wr_en = 0; wr_tr = 0; wr_way = 0; wr_set = 0; wr_data = 0;
    rd_tr = 0; rd_way = 0; rd_set = 0;
    repeat (3) @(negedge clk);
    check("R12", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    rst_n = 1;
    // R12 reset state through read port
    cur_req = "R12";
    look(0, 0, 0); look(1, 1, 15);

    // R1 bypass both ways, ci boundary
    cur_req = "R1";
    prb_vaddr = 32'h8000_1234;
    fetch(32'h7FFF_FFFC); fetch(32'h8000_0000);
    xlate_en = 1;
    fetch(32'hC000_0010);
    mmu_present = 1; xlate_en = 0;
    fetch(32'h0000_4000);
    xlate_en = 1;

    A = 32'h1234_5678; sa = m_set(A);
    B = A ^ 32'h0002_0000;   // same set, other tag
    C = A ^ 32'h0000_2000;   // same tag, other set
    D = 32'h0765_4321;

    // R8 miss on empty array, entries unchanged
    cur_req = "R8";
    fetch(A); look(0, 0, sa); look(0, 1, sa);

    // R13 load entries; R3 valid bit required
    cur_req = "R13";
    put(0, 0, sa, m_tag(A));                      // way0 invalid
    put(0, 1, sa, m_tag(A) | 32'h81);             // way1 valid age 2
    put(1, 1, sa, 32'hABCD_E000 | 32'hC0);        // both exec bits
    look(0, 1, sa);
    cur_req = "R3";
    sup_mode = 0;
    fetch(A);                                     // hits way1
    // R5 physical address with offset
    cur_req = "R5";
    fetch(A | 32'h1FFF);
    // R2 index and tag slicing
    cur_req = "R2";
    fetch(B); fetch(C);
    // R3 lowest way wins
    cur_req = "R3";
    put(0, 0, sa, m_tag(A) | 32'h1);
    put(1, 0, sa, 32'h0F0F_0000 | 32'h40);
    fetch(A);
    // R4 ages: preset way1 to 2, way0 to 0, hit way0
    cur_req = "R4";
    put(0, 1, sa, m_tag(A) | 32'h81);
    put(0, 0, sa, m_tag(A) | 32'h01);
    fetch(A); look(0, 0, sa); look(0, 1, sa);
    fetch(A); look(0, 1, sa);
    // R6 permissions
    cur_req = "R6";
    put(1, 0, sa, 32'h0F0F_0000 | 32'h80);        // supervisor only
    sup_mode = 0; fetch(A);
    sup_mode = 1; fetch(A);
    put(1, 0, sa, 32'h0F0F_0000 | 32'h40);        // user only
    fetch(A); look(0, 0, sa);
    sup_mode = 0; fetch(A);
    // R7 cache inhibit bit
    cur_req = "R7";
    put(1, 0, sa, 32'h2222_0000 | 32'h42);
    fetch(A | 32'h10);
    // R9 probe: hit, fault, miss, ages untouched
    cur_req = "R9";
    put(0, 1, sa, m_tag(A) | 32'h41);
    prb_vaddr = A; look(0, 1, sa);
    prb_vaddr = A; sup_mode = 1; look(0, 0, sa);
    sup_mode = 0; prb_vaddr = B; look(0, 1, sa);
    prb_vaddr = D; look(0, 0, sa);
    // R8 miss leaves set untouched
    cur_req = "R8";
    fetch(B); look(0, 0, sa); look(0, 1, sa);
    // R13 write wins over same-cycle aging
    cur_req = "R13";
    wr_en = 1; wr_tr = 0; wr_way = 0; wr_set = 4'(sa); wr_data = m_tag(A) | 32'h41;
    req_valid = 1; req_vaddr = A;
    tick();
    wr_en = 0; req_valid = 0;
    look(0, 0, sa); look(0, 1, sa);
    // R11 idle cycles and back-to-back requests
    cur_req = "R11";
    tick(); fetch(D); fetch(A); tick();
    finish_run();
  end
endmodule